// File: doc/BRIEF.md
# Conversion Result Output Coding Formatter

This block sits between a data converter's raw result and its parallel output pins. Each time a conversion finishes, it captures the 16-bit result (an offset-binary code where zero stands for the most negative input) and an out-of-range indication. It then presents the result in one of four codings. A single complement-select input chooses between straight and bitwise-inverted offset binary. A pair of sign outputs, one the inverse of the other, lets the board take two's complement or complementary two's complement by wiring the inverted sign line in place of the primary one.

An overflow flag follows an asymmetric full-scale rule. A word of all zeros always raises it. A word of all ones raises it only when the input is strictly beyond that endpoint. Because the rule is applied to the formatted word, it swaps ends when complementing is on. An active-low output enable is modelled as a separate drive-enable output. Whenever the bus is not driven, it is forced to all zeros.

While the converter is busy (end-of-conversion high), new enable and complement settings are held off. They take effect on the clock where end-of-conversion is seen low again, which is the same clock that captures the new result.

Top module: `adc_code_formatter`

## Requirements
- R1: With complement select applied as 0, `dout` equals the captured code unchanged (offset binary; code 0x0000 is the most negative input).
- R2: With complement select applied as 1, `dout` is the bitwise inverse of the captured code (complementary offset binary).
- R3: While driven, `msb` equals `dout[15]` and `msb_n` equals its inverse, so `{msb_n, dout[14:0]}` forms the two's complement variant of the selected coding.
- R4: While driven, `ovf` is 1 when `dout` is all zeros, or when `dout` is all ones and the captured out-of-range bit is 1; it is 0 in every other case.
- R5: An applied `oe_n` of 1 gives `drv_en` = 0 with `dout`, `msb`, `msb_n` and `ovf` all 0; an applied `oe_n` of 0 gives `drv_en` = 1.
- R6: `cpl_sel` and `oe_n` are applied on every clock where `eoc` is sampled 0. Changes made while `eoc` is 1 do not reach the outputs, which stay stable, until the first clock with `eoc` back at 0.
- R7: The code and out-of-range bit are captured on the clock where `eoc` is sampled 0 after being 1, and appear on the outputs after that edge. Changes to `conv_code` at any other time are ignored.
- R8: During reset, `drv_en` and all data outputs are 0. The applied complement select resets to the parameter `CPL_RST` (default 1, standing for an unconnected pin pulled high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_code | input | 16 | Raw offset-binary conversion result |
| over_rng | input | 1 | Input was strictly beyond the full-scale endpoint |
| eoc | input | 1 | End-of-conversion; high while a conversion is busy |
| cpl_sel | input | 1 | Complement select: 1 inverts every output bit |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 16 | Formatted data word, zero when not driven |
| msb | output | 1 | Primary sign/MSB line |
| msb_n | output | 1 | Inverted MSB line |
| ovf | output | 1 | Overflow flag |
| drv_en | output | 1 | High when the outputs are driven (not high impedance) |

## Verification
The stability property assumes that `eoc` is low during reset and that `conv_code` and `over_rng` are settled by the clock on which `eoc` falls. The bench changes inputs only at the falling clock edge, loads the code together with the rise of `eoc`, and releases reset with `eoc` low. The overflow properties take the out-of-range input as meaningful only when the code sits at an endpoint. The bench therefore pairs an asserted out-of-range bit with mid-scale codes only in cases where the expected flag is still 0.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
   // settings applied to the output path
   typedef struct packed {
      logic cpl;    // 1 = invert every output bit
      logic oe_n;   // 1 = outputs not driven
   } fmt_cfg_t;
endpackage

// File: rtl/adcfmt_ctrl.sv
module adcfmt_ctrl
   import adcfmt_pkg::*;
#(
   parameter bit CPL_RST = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     eoc,
   input  logic     cpl_sel,
   input  logic     oe_n,
   output fmt_cfg_t cfg,
   output logic     capture
);
   logic eoc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eoc_q    <= 1'b0;
         cfg.cpl  <= CPL_RST;
         cfg.oe_n <= 1'b1;
      end else begin
         eoc_q <= eoc;
         if (!eoc) begin
            cfg.cpl  <= cpl_sel;
            cfg.oe_n <= oe_n;
         end
      end
   end

   assign capture = eoc_q & ~eoc;
endmodule

// File: rtl/adcfmt_capture.sv
module adcfmt_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] code_in,
   input  logic              ovr_in,
   output logic [DATA_W-1:0] code_q,
   output logic              ovr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         ovr_q  <= 1'b0;
      end else if (capture) begin
         code_q <= code_in;
         ovr_q  <= ovr_in;
      end
   end
endmodule

// File: rtl/adcfmt_map.sv
module adcfmt_map
   import adcfmt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] code,
   input  logic              ovr,
   input  fmt_cfg_t          cfg,
   output logic [DATA_W-1:0] dout,
   output logic              msb,
   output logic              msb_n,
   output logic              ovf,
   output logic              drv_en
);
   localparam int TOP = DATA_W - 1;

   logic [DATA_W-1:0] word;
   logic              at_zero, at_ones, flag;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign word[b] = code[b] ^ cfg.cpl;
   end

   assign at_zero = ~|word;
   assign at_ones = &word;
   assign flag    = at_zero | (at_ones & ovr);
   assign drv_en  = ~cfg.oe_n;

   always_comb begin
      dout  = '0;
      msb   = 1'b0;
      msb_n = 1'b0;
      ovf   = 1'b0;
      if (drv_en) begin
         dout  = word;
         msb   = word[TOP];
         msb_n = ~word[TOP];
         ovf   = flag;
      end
   end
endmodule

// File: rtl/adc_code_formatter.sv
module adc_code_formatter
   import adcfmt_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit CPL_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] conv_code,
   input  logic              over_rng,
   input  logic              eoc,
   input  logic              cpl_sel,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              msb,
   output logic              msb_n,
   output logic              ovf,
   output logic              drv_en
);
   if (DATA_W < 2) begin : g_bad_width
      $error("adc_code_formatter: DATA_W must be at least 2");
   end

   fmt_cfg_t          cfg;
   logic              capture;
   logic [DATA_W-1:0] code_q;
   logic              ovr_q;

   adcfmt_ctrl #(.CPL_RST(CPL_RST)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .eoc(eoc), .cpl_sel(cpl_sel),
      .oe_n(oe_n), .cfg(cfg), .capture(capture)
   );

   adcfmt_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .capture(capture), .code_in(conv_code),
      .ovr_in(over_rng), .code_q(code_q), .ovr_q(ovr_q)
   );

   adcfmt_map #(.DATA_W(DATA_W)) u_map (
      .code(code_q), .ovr(ovr_q), .cfg(cfg), .dout(dout), .msb(msb),
      .msb_n(msb_n), .ovf(ovf), .drv_en(drv_en)
   );
endmodule

// File: rtl/adcfmt_chk.sv
module adcfmt_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eoc,
   input logic [DATA_W-1:0] dout,
   input logic              msb,
   input logic              msb_n,
   input logic              ovf,
   input logic              drv_en
);
   AST_SIGN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (msb == dout[DATA_W-1]) && (msb_n != msb)); // R3
   AST_OVF_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && dout == '0) |-> ovf); // R4
   AST_OVF_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && dout != '0 && dout != '1) |-> !ovf); // R4
   AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |-> (dout == '0 && !msb && !msb_n && !ovf)); // R5
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eoc) |-> ($stable(dout) && $stable(drv_en) && $stable(ovf))); // R6
endmodule

bind adc_code_formatter adcfmt_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .eoc(eoc), .dout(dout), .msb(msb),
   .msb_n(msb_n), .ovf(ovf), .drv_en(drv_en)
);

// File: tb/adc_code_formatter_test.sv
module adc_code_formatter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] conv_code = '0;
   logic        over_rng = 1'b0;
   logic        eoc = 1'b0;
   logic        cpl_sel = 1'b1;
   logic        oe_n = 1'b1;
   logic [15:0] dout;
   logic        msb, msb_n, ovf, drv_en;
   int          checks = 0;
   int          errors = 0;

   always #4 clk = ~clk;

   adc_code_formatter uut (
      .clk(clk), .rst_n(rst_n), .conv_code(conv_code), .over_rng(over_rng),
      .eoc(eoc), .cpl_sel(cpl_sel), .oe_n(oe_n), .dout(dout), .msb(msb),
      .msb_n(msb_n), .ovf(ovf), .drv_en(drv_en)
   );

   // {code, out-of-range, complement, expected word, expected overflow}
   localparam logic [34:0] VEC [10] = '{
      {16'h1234, 1'b0, 1'b0, 16'h1234, 1'b0},
      {16'h1234, 1'b0, 1'b1, 16'hEDCB, 1'b0},
      {16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1},
      {16'hFFFF, 1'b0, 1'b0, 16'hFFFF, 1'b0},
      {16'hFFFF, 1'b1, 1'b0, 16'hFFFF, 1'b1},
      {16'h0000, 1'b1, 1'b1, 16'hFFFF, 1'b1},
      {16'h0000, 1'b0, 1'b1, 16'hFFFF, 1'b0},
      {16'hFFFF, 1'b0, 1'b1, 16'h0000, 1'b1},
      {16'h8000, 1'b1, 1'b0, 16'h8000, 1'b0},
      {16'h7FFF, 1'b0, 1'b1, 16'h8000, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic convert(input logic [15:0] code, input logic ovr);
      conv_code = code;
      over_rng  = ovr;
      eoc       = 1'b1;
      @(negedge clk);
      eoc = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(drv_en == 1'b0, "R8 drv_en in reset", {31'd0, drv_en}, 32'd0);
      chk(dout == 16'h0 && !ovf && !msb, "R8 outputs in reset", {16'd0, dout}, 32'd0);
      rst_n = 1'b1;

      // vector table: R1 R2 R3 R4
      foreach (VEC[i]) begin
         cpl_sel = VEC[i][17];
         oe_n    = 1'b0;
         @(negedge clk);
         convert(VEC[i][34:19], VEC[i][18]);
         chk(dout == VEC[i][16:1], VEC[i][17] ? "R2 inverted word" : "R1 straight word",
             {16'd0, dout}, {16'd0, VEC[i][16:1]});
         chk(msb == VEC[i][16] && msb_n == ~VEC[i][16], "R3 sign pair",
             {30'd0, msb, msb_n}, {30'd0, VEC[i][16], ~VEC[i][16]});
         chk(ovf == VEC[i][0], "R4 overflow flag", {31'd0, ovf}, {31'd0, VEC[i][0]});
         chk(drv_en == 1'b1, "R5 driven", {31'd0, drv_en}, 32'd1);
      end

      // R7: capture only at eoc fall
      cpl_sel = 1'b0;
      @(negedge clk);
      convert(16'h1234, 1'b0);
      chk(dout == 16'h1234, "R7 captured word", {16'd0, dout}, 32'h1234);
      conv_code = 16'hABCD;
      repeat (3) @(negedge clk);
      chk(dout == 16'h1234, "R7 code change ignored", {16'd0, dout}, 32'h1234);

      // R6: complement change held off while busy
      eoc = 1'b1;
      conv_code = 16'h1234;
      cpl_sel = 1'b1;
      repeat (3) @(negedge clk);
      chk(dout == 16'h1234, "R6 complement held while busy", {16'd0, dout}, 32'h1234);
      eoc = 1'b0;
      @(negedge clk);
      chk(dout == 16'hEDCB, "R6 complement applied at fall", {16'd0, dout}, 32'hEDCB);

      // R6 R5: enable change held off while busy
      eoc = 1'b1;
      oe_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(drv_en == 1'b1, "R6 enable held while busy", {31'd0, drv_en}, 32'd1);
      eoc = 1'b0;
      @(negedge clk);
      chk(drv_en == 1'b0, "R5 disabled after fall", {31'd0, drv_en}, 32'd0);
      chk(dout == 16'h0 && !msb && !msb_n && !ovf, "R5 quiet bus",
          {16'd0, dout}, 32'd0);
      oe_n = 1'b0;
      @(negedge clk);
      chk(drv_en == 1'b1 && dout == 16'hEDCB, "R5 re-enabled when idle",
          {15'd0, drv_en, dout}, {15'd0, 1'b1, 16'hEDCB});

      // R1: complement change while idle applies to held word
      cpl_sel = 1'b0;
      @(negedge clk);
      chk(dout == 16'h1234, "R1 idle complement change", {16'd0, dout}, 32'h1234);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule